// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a two-bank single-data-rate SDRAM from reset to a usable state. Reset starts a stabilization pause measured in clock cycles and derived from a clock-frequency parameter. During the pause only no-operation commands go out, and both CKE and the byte-mask output are held high so that nothing drives the data bus. After the pause the sequencer precharges every bank. It then programs the mode register from its configuration inputs and issues a parameterised number of auto-refresh commands (at least eight). A parameter selects whether the refreshes come before or after the mode write.

Each wait between commands is timed by a shared down-counter, which is loaded from cycle-count parameters for the precharge period, the refresh cycle and the mode-write recovery. One cycle after the last wait expires, the sequencer raises a done flag. That flag stays high until the next reset, and from then on only no-operation commands are driven. The memory controller watches this flag and takes over the command bus once it is high.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is low: init_done is 0, cke is 1, dqm is 1, and the command is NOP. Commands are encoded {cs_n,ras_n,cas_n,we_n}, with NOP = 0111.
- R2: For the first CLK_MHZ*PAUSE_US cycles after reset is released (cycles 0 up to that count minus one), only NOP is driven, and cke and dqm stay high.
- R3: The first non-NOP command is a precharge (0010) in cycle CLK_MHZ*PAUSE_US. Its address has bit 10 set and all other bits clear, which selects all banks.
- R4: The mode write (0000) carries this address layout: bits 2:0 are burst length, bit 3 is wrap type, bits 6:4 are read latency, bits 8:7 are 00, bit 9 is the write-burst mode, and all higher bits are 0.
- R5: Exactly REFRESH_COUNT auto-refresh commands (0001) are issued, and REFRESH_COUNT is never below 8.
- R6: The command after the precharge comes TRP_CYC cycles after it. Consecutive refreshes, and a refresh and the command after it, are TRC_CYC cycles apart. A mode write is followed by TMRD_CYC-1 NOP cycles before the next command.
- R7: With REFRESH_FIRST=0 the order is precharge, mode write, refreshes. With REFRESH_FIRST=1 the order is precharge, refreshes, mode write.
- R8: init_done rises one cycle after the last wait expires and stays high until reset. From that cycle on, dqm is low and only NOP is driven.
- R9: cke is high in every cycle, so it has been high at least one cycle before the mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | Wrap type: 0 sequential, 1 interleaved |
| cfg_read_lat | input | 3 | Read latency code for the mode word |
| cfg_single_wr | input | 1 | Write-burst mode: 1 single-location writes |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (mode word or precharge-all flag) |
| ba | output | BANK_W | Bank select, always 0 |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data byte mask, high until init_done |
| init_done | output | 1 | Bring-up complete |

## Verification
Every command is due in a cycle that follows from the reset release. The precharge comes at the pause length P. The next command follows TRP_CYC later, refreshes step by TRC_CYC, and the mode write is followed by a TMRD_CYC gap. init_done is due one cycle after the final wait expires. The bench counts the clock edges since release and builds a queue of the expected commands, each tagged with its exact cycle, from these formulas. A monitor samples on the falling edge, pops one entry for each non-NOP command and compares the cycle, the encoding and the address. Each cycle it also checks the NOP, CKE and DQM levels of the pause and the level init_done should have in that cycle.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;
   // command code, bit order {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } cmd_t;

   typedef enum logic [2:0] {
      ST_PAUSE,
      ST_PRE,
      ST_WAIT_RP,
      ST_REF,
      ST_WAIT_RC,
      ST_MRS,
      ST_WAIT_MRD,
      ST_DONE
   } boot_state_t;
endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
   parameter int CNT_W     = 16,
   parameter int RESET_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_W'(RESET_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_boot_mode_word.sv
module sdram_boot_mode_word #(
   parameter int ADDR_W = 11
) (
   input  logic [2:0]        burst_len,
   input  logic              interleave,
   input  logic [2:0]        read_lat,
   input  logic              single_wr,
   output logic [ADDR_W-1:0] word
);
   localparam int LOW_W = 10;

   logic [LOW_W-1:0] low;
   assign low = {single_wr, 2'b00, read_lat, interleave, burst_len};

   generate
      if (ADDR_W > LOW_W) begin : g_pad
         assign word = {{(ADDR_W-LOW_W){1'b0}}, low};
      end else begin : g_exact
         assign word = low[ADDR_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
   import sdram_boot_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter int TRP_CYC       = 3,
   parameter int TRC_CYC       = 9,
   parameter int TMRD_CYC      = 2,
   parameter int REFRESH_COUNT = 8,
   parameter bit REFRESH_FIRST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expired,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output boot_state_t      state
);
   localparam int REF_W = $clog2(REFRESH_COUNT + 1);
   localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(TRP_CYC - 2);
   localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(TRC_CYC - 2);
   localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(TMRD_CYC - 2);

   boot_state_t nxt;
   boot_state_t after_rp, after_refs, after_mrd;
   logic [REF_W-1:0] refs_left;

   generate
      if (REFRESH_FIRST) begin : g_ref_first
         assign after_rp   = ST_REF;
         assign after_refs = ST_MRS;
         assign after_mrd  = ST_DONE;
      end else begin : g_mrs_first
         assign after_rp   = ST_MRS;
         assign after_refs = ST_DONE;
         assign after_mrd  = ST_REF;
      end
   endgenerate

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_val = '0;
      unique case (state)
         ST_PAUSE:    if (expired) nxt = ST_PRE;
         ST_PRE:      begin nxt = ST_WAIT_RP;  load = 1'b1; load_val = LD_RP;  end
         ST_WAIT_RP:  if (expired) nxt = after_rp;
         ST_REF:      begin nxt = ST_WAIT_RC;  load = 1'b1; load_val = LD_RC;  end
         ST_WAIT_RC:  if (expired) nxt = (refs_left != '0) ? ST_REF : after_refs;
         ST_MRS:      begin nxt = ST_WAIT_MRD; load = 1'b1; load_val = LD_MRD; end
         ST_WAIT_MRD: if (expired) nxt = after_mrd;
         ST_DONE:     nxt = ST_DONE;
         default:     nxt = ST_PAUSE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_PAUSE;
         refs_left <= REF_W'(REFRESH_COUNT);
      end else begin
         state <= nxt;
         if (state == ST_REF)
            refs_left <= refs_left - 1'b1;
      end
   end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int ADDR_W        = 11,
   parameter int BANK_W        = 1,
   parameter int CLK_MHZ       = 200,
   parameter int PAUSE_US      = 200,
   parameter int TRP_CYC       = 3,
   parameter int TRC_CYC       = 9,
   parameter int TMRD_CYC      = 2,
   parameter int REFRESH_COUNT = 8,
   parameter bit REFRESH_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_interleave,
   input  logic [2:0]        cfg_read_lat,
   input  logic              cfg_single_wr,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] ba,
   output logic              cke,
   output logic              dqm,
   output logic              init_done
);
   localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
   localparam int WAIT_MAX  = (TRC_CYC > TRP_CYC) ?
                              ((TRC_CYC > TMRD_CYC) ? TRC_CYC : TMRD_CYC) :
                              ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC);
   localparam int CNT_MAX   = (PAUSE_CYC > WAIT_MAX) ? PAUSE_CYC : WAIT_MAX;
   localparam int CNT_W     = $clog2(CNT_MAX + 1);
   localparam int ALL_BANKS_BIT = 10;

   generate
      if (ADDR_W < ALL_BANKS_BIT + 1) begin : g_bad_addr
         $error("ADDR_W must reach the all-banks bit");
      end
      if (REFRESH_COUNT < 8) begin : g_bad_refs
         $error("REFRESH_COUNT must be at least 8");
      end
      if (TRP_CYC < 2 || TRC_CYC < 2 || TMRD_CYC < 2) begin : g_bad_wait
         $error("wait cycle counts must be at least 2");
      end
      if (PAUSE_CYC < 1) begin : g_bad_pause
         $error("pause must be at least one cycle");
      end
   endgenerate

   logic             expired, load;
   logic [CNT_W-1:0] load_val;
   logic [ADDR_W-1:0] mode_word;
   boot_state_t      state;
   cmd_t             cmd;
   logic             pausing;

   sdram_boot_timer #(
      .CNT_W     (CNT_W),
      .RESET_VAL (PAUSE_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   sdram_boot_fsm #(
      .CNT_W         (CNT_W),
      .TRP_CYC       (TRP_CYC),
      .TRC_CYC       (TRC_CYC),
      .TMRD_CYC      (TMRD_CYC),
      .REFRESH_COUNT (REFRESH_COUNT),
      .REFRESH_FIRST (REFRESH_FIRST)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .expired  (expired),
      .load     (load),
      .load_val (load_val),
      .state    (state)
   );

   sdram_boot_mode_word #(.ADDR_W(ADDR_W)) u_mode (
      .burst_len  (cfg_burst_len),
      .interleave (cfg_interleave),
      .read_lat   (cfg_read_lat),
      .single_wr  (cfg_single_wr),
      .word       (mode_word)
   );

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      unique case (state)
         ST_PRE: begin cmd = CMD_PRE; addr[ALL_BANKS_BIT] = 1'b1; end
         ST_REF: cmd = CMD_REF;
         ST_MRS: begin cmd = CMD_MRS; addr = mode_word; end
         default: cmd = CMD_NOP;
      endcase
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign ba        = '0;
   assign cke       = 1'b1;   // held high from reset onward
   assign init_done = (state == ST_DONE);
   assign dqm       = ~init_done;
   assign pausing   = (state == ST_PAUSE);
endmodule

module sdram_boot_seq_chk #(
   parameter int ADDR_W        = 11,
   parameter int REFRESH_COUNT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              cke,
   input logic              dqm,
   input logic              init_done,
   input logic              pausing
);
   localparam int RC_W = $clog2(REFRESH_COUNT + 2);

   logic [3:0]      c;
   logic [RC_W-1:0] refs_seen;
   logic            pre_seen;

   assign c = {cs_n, ras_n, cas_n, we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         refs_seen <= '0;
         pre_seen  <= 1'b0;
      end else begin
         if (c == 4'b0001) refs_seen <= refs_seen + 1'b1;
         if (c == 4'b0010) pre_seen  <= 1'b1;
      end
   end

   a_r2_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      pausing |-> (c == 4'b0111 && cke && dqm));
   a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 4'b0010) |-> addr[10]);
   a_r7_mrs_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 4'b0000) |-> pre_seen);
   a_r6_mrs_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 4'b0000) |=> (c == 4'b0111));
   a_r5_ref_count: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (refs_seen == RC_W'(REFRESH_COUNT)));
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (c == 4'b0111 && !dqm));
   a_r9_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
      (c == 4'b0000) |-> (cke && $past(cke)));
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
   .ADDR_W        (ADDR_W),
   .REFRESH_COUNT (REFRESH_COUNT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .addr      (addr),
   .cke       (cke),
   .dqm       (dqm),
   .init_done (init_done),
   .pausing   (pausing)
);

// File: tb/test_sdram_boot_seq.sv
`timescale 1ns/1ps
module test_sdram_boot_seq;
   localparam int AW = 11, P = 400, TRP = 3, TRC = 9, TMRD = 2, NREF = 8;

   typedef struct {
      int         cyc;
      logic [3:0] cmd;
      logic [AW-1:0] addr;
      bit         chk_addr;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [2:0] bl0, lat0, bl1, lat1;
   logic il0, sw0, il1, sw1;
   logic cs0, ras0, cas0, we0, cke0, dqm0, done0;
   logic cs1, ras1, cas1, we1, cke1, dqm1, done1;
   logic [AW-1:0] addr0, addr1;
   logic [0:0] ba0, ba1;

   int checks = 0, fails = 0, cyc = 0;
   exp_t q0[$], q1[$];

   sdram_boot_seq #(.ADDR_W(AW), .CLK_MHZ(200), .PAUSE_US(2), .TRP_CYC(TRP),
      .TRC_CYC(TRC), .TMRD_CYC(TMRD), .REFRESH_COUNT(NREF), .REFRESH_FIRST(1'b0))
   i_sdram_boot_seq (.clk(clk), .rst_n(rst_n), .cfg_burst_len(bl0),
      .cfg_interleave(il0), .cfg_read_lat(lat0), .cfg_single_wr(sw0),
      .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .addr(addr0),
      .ba(ba0), .cke(cke0), .dqm(dqm0), .init_done(done0));

   sdram_boot_seq #(.ADDR_W(AW), .CLK_MHZ(200), .PAUSE_US(2), .TRP_CYC(TRP),
      .TRC_CYC(TRC), .TMRD_CYC(TMRD), .REFRESH_COUNT(NREF), .REFRESH_FIRST(1'b1))
   i_sdram_boot_seq_rf (.clk(clk), .rst_n(rst_n), .cfg_burst_len(bl1),
      .cfg_interleave(il1), .cfg_read_lat(lat1), .cfg_single_wr(sw1),
      .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .addr(addr1),
      .ba(ba1), .cke(cke1), .dqm(dqm1), .init_done(done1));

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   function automatic logic [AW-1:0] mode_of(logic [2:0] bl, logic il,
                                             logic [2:0] lat, logic sw);
      logic [AW-1:0] w = '0;
      w[2:0] = bl; w[3] = il; w[6:4] = lat; w[9] = sw;   // R4 layout
      return w;
   endfunction

   function automatic int done_cyc(bit rf);
      return rf ? P + TRP + NREF*TRC + TMRD : P + TRP + TMRD + NREF*TRC;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // driver: push the expected command stream of one instance (R3 R5 R6 R7)
   task automatic push_expected(bit rf, logic [AW-1:0] mw);
      exp_t e;
      int t = P;
      e.cyc = t; e.cmd = 4'b0010; e.addr = AW'(1) << 10; e.chk_addr = 1;
      if (rf) q1.push_back(e); else q0.push_back(e);
      t += TRP;
      if (!rf) begin
         e.cyc = t; e.cmd = 4'b0000; e.addr = mw; e.chk_addr = 1;
         q0.push_back(e); t += TMRD;
      end
      for (int i = 0; i < NREF; i++) begin
         e.cyc = t; e.cmd = 4'b0001; e.addr = '0; e.chk_addr = 0;
         if (rf) q1.push_back(e); else q0.push_back(e);
         t += TRC;
      end
      if (rf) begin
         e.cyc = t; e.cmd = 4'b0000; e.addr = mw; e.chk_addr = 1;
         q1.push_back(e);
      end
   endtask

   // monitor: one instance per call, sampled on the falling edge
   task automatic watch(bit rf, logic [3:0] c, logic [AW-1:0] a,
                        logic ck, logic dm, logic dn);
      exp_t e;
      string tag = rf ? "[rf]" : "[mf]";
      if (cyc < P) check(c == 4'b0111 && ck && dm, "R2", {tag, " pause pins"},
                         {c, ck, dm}, 12'h0711);
      check(ck, "R9", {tag, " cke"}, ck, 1);
      check(dn == (cyc >= done_cyc(rf)), "R8", {tag, " init_done"}, dn,
            cyc >= done_cyc(rf));
      if (dn) check(!dm && c == 4'b0111, "R8", {tag, " quiet after done"}, {c, dm}, 8'h70);
      if (c != 4'b0111) begin
         if ((rf ? q1.size() : q0.size()) == 0) begin
            check(0, "R5", {tag, " unexpected command"}, c, 4'h7);
         end else begin
            e = rf ? q1.pop_front() : q0.pop_front();
            check(e.cyc == cyc, "R6", {tag, " command cycle"}, cyc, e.cyc);
            check(e.cmd == c, "R7", {tag, " command order"}, c, e.cmd);
            if (e.chk_addr)
               check(e.addr == a, (c == 4'b0000) ? "R4" : "R3",
                     {tag, " address"}, a, e.addr);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         watch(1'b0, {cs0, ras0, cas0, we0}, addr0, cke0, dqm0, done0);
         watch(1'b1, {cs1, ras1, cas1, we1}, addr1, cke1, dqm1, done1);
      end
   end

   task automatic check_reset();
      check(!done0 && cke0 && dqm0 && {cs0, ras0, cas0, we0} == 4'b0111, "R1",
            "reset state mf", {done0, cke0, dqm0, cs0, ras0, cas0, we0}, 7'h37);
      check(!done1 && cke1 && dqm1 && {cs1, ras1, cas1, we1} == 4'b0111, "R1",
            "reset state rf", {done1, cke1, dqm1, cs1, ras1, cas1, we1}, 7'h37);
   endtask

   task automatic run_once();
      q0.delete(); q1.delete();
      push_expected(1'b0, mode_of(bl0, il0, lat0, sw0));
      push_expected(1'b1, mode_of(bl1, il1, lat1, sw1));
      repeat (3) @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      wait (cyc == done_cyc(1'b0) + 25);
      @(negedge clk);
      check(q0.size() == 0, "R5", "mf commands outstanding", q0.size(), 0);
      check(q1.size() == 0, "R5", "rf commands outstanding", q1.size(), 0);
      rst_n = 1'b0;
      @(negedge clk);
      check_reset();
   endtask

   initial begin
      bl0 = 3'b011; il0 = 1'b0; lat0 = 3'b011; sw0 = 1'b0;
      bl1 = 3'b010; il1 = 1'b1; lat1 = 3'b010; sw1 = 1'b1;
      run_once();
      bl0 = 3'b111; il0 = 1'b0; lat0 = 3'b010; sw0 = 1'b1;
      bl1 = 3'b000; il1 = 1'b1; lat1 = 3'b011; sw1 = 1'b0;
      run_once();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule